// File: doc/BRIEF.md
# Vector Even/Odd Widening Multiplier

This unit executes a family of sixteen vector multiply instructions on 128-bit operands. Each instruction picks either the even-numbered or the odd-numbered elements of two source vectors. It multiplies each selected pair as signed or unsigned numbers at byte, halfword, word or doubleword size. The products are twice the element width, so the selected half of the elements fills the whole 128-bit destination.

The 32-bit instruction word is decoded inside the unit. Words that do not match the multiply pattern come back marked illegal. So do doubleword forms issued while the newer architecture level is off. The unit is a two-stage pipeline with a valid/ready handshake on both sides. It carries the destination register index alongside the result, so the issuing logic can write it back to the register file.

Top module: `vmul_eo_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:26 equal 000100, bit 10 is 0 and bits 5:0 equal 001000. Any other word is illegal.
- R2: Bit 9 picks the elements. When it is 1 the even elements 0, 2, 4, ... are used; when it is 0 the odd elements 1, 3, 5, ... are used. Element 0 sits in the most significant bits of each vector.
- R3: Bit 8 picks signedness. When it is 1 both operands are sign-extended before the multiply; when it is 0 both are zero-extended.
- R4: Bits 7:6 give the element size: 00 byte, 01 halfword, 10 word, 11 doubleword. Product i comes from the i-th selected pair and fills destination slot i, which is twice the element width, with slot 0 in the most significant bits.
- R5: For the doubleword forms the even form uses doubleword 0 (bits 127:64) of each source and the odd form uses doubleword 1. The full 128-bit product has its high half in bits 127:64 of the result.
- R6: The signed doubleword product is exact for the most negative 64-bit value. For example, -2^63 times -2^63 gives 2^126.
- R7: The doubleword forms are legal only when new_isa_en is high. The byte, halfword and word forms are legal whatever its value.
- R8: An illegal instruction completes with res_illegal high, res_valid low and res_data zero.
- R9: An instruction accepted at a clock edge (in_valid and in_ready both high) appears on the outputs right after the next edge when out_ready stays high. The unit then accepts a new instruction every cycle.
- R10: While a result or an illegal flag is presented and out_ready is low, res_valid, res_illegal, res_data and res_dst hold steady. Nothing is lost or duplicated.
- R11: A synchronous active-high reset clears res_valid and res_illegal.
- R12: Bits 25:21 of the instruction are returned on res_dst with the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_src_a | input | 128 | First source vector |
| in_src_b | input | 128 | Second source vector |
| new_isa_en | input | 1 | Enables the doubleword forms |
| out_ready | input | 1 | Consumer takes the presented result |
| res_valid | output | 1 | Legal result presented |
| res_illegal | output | 1 | Illegal instruction completion presented |
| res_dst | output | 5 | Destination register index of the presented result |
| res_data | output | 128 | Result vector |

## Verification
On every cycle the assertions check four things. Presented outputs stay frozen under back-pressure. A full, stalled pipeline refuses input. An illegal completion carries zero data. A doubleword form without the newer level never decodes as legal. Reset clearing both output flags is checked as well.

Only the bench's scenarios can show that the products are right. This covers element selection by parity, sign versus zero extension at every size, and the most-negative doubleword case. The scenarios also show the exact one-edge latency and the in-order delivery under random back-pressure, and they compare the results against an independently computed model.

// File: rtl/vmul_eo_pkg.sv
`timescale 1ns/1ps
package vmul_eo_pkg;
    localparam int unsigned VEC_W     = 128;
    localparam int unsigned INSTR_W   = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned BYTE_W    = 8;
    localparam logic [5:0]  PRIMARY_OP = 6'b000100;
    localparam logic [5:0]  MUL_SUFFIX = 6'b001000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DWRD = 2'd3
    } esize_e;

    typedef struct packed {
        logic                 legal;
        logic                 even;
        logic                 sgn;
        esize_e               size;
        logic [REG_IDX_W-1:0] dst;
    } dec_t;

    typedef struct packed {
        logic             occ;
        dec_t             dec;
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
    } stage1_t;

    typedef struct packed {
        logic                 occ;
        logic                 ill;
        logic [REG_IDX_W-1:0] dst;
        logic [VEC_W-1:0]     data;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;
endpackage

// File: rtl/vmul_eo_decode.sv
`timescale 1ns/1ps
module vmul_eo_decode
    import vmul_eo_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               ext_en,
    output dec_t               dec
);
    // source register fields are resolved by the register file, not here
    logic unused_src_fields;
    assign unused_src_fields = ^instr[20:11];

    logic pattern_ok;
    logic size_ok;

    always_comb begin
        pattern_ok = (instr[31:26] == PRIMARY_OP) && !instr[10]
                     && (instr[5:0] == MUL_SUFFIX);
        size_ok    = (instr[7:6] != 2'b11) || ext_en;
        dec.legal  = pattern_ok && size_ok;
        dec.even   = instr[9];
        dec.sgn    = instr[8];
        dec.size   = esize_e'(instr[7:6]);
        dec.dst    = instr[25:21];
    end
endmodule

// File: rtl/vmul_eo_lanes.sv
`timescale 1ns/1ps
module vmul_eo_lanes #(
    parameter int unsigned VW = 128,
    parameter int unsigned EW = 8
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    input  logic          even,
    input  logic          sgn,
    output logic [VW-1:0] prod
);
    localparam int unsigned PW    = 2 * EW;
    localparam int unsigned NPROD = VW / PW;

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        logic [EW-1:0] ea_d, eb_d;
        logic [PW-1:0] xa_d, xb_d;

        always_comb begin
            // element 2p or 2p+1, big-endian numbering
            ea_d = even ? a[VW-1-(2*p)*EW -: EW] : a[VW-1-(2*p+1)*EW -: EW];
            eb_d = even ? b[VW-1-(2*p)*EW -: EW] : b[VW-1-(2*p+1)*EW -: EW];
            xa_d = {{EW{sgn & ea_d[EW-1]}}, ea_d};
            xb_d = {{EW{sgn & eb_d[EW-1]}}, eb_d};
        end

        // low PW bits of the extended product are exact for both signednesses
        assign prod[VW-1-p*PW -: PW] = xa_d * xb_d;
    end
endmodule

// File: rtl/vmul_eo_unit.sv
`timescale 1ns/1ps
module vmul_eo_unit
    import vmul_eo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [INSTR_W-1:0]   in_instr,
    input  logic [VEC_W-1:0]     in_src_a,
    input  logic [VEC_W-1:0]     in_src_b,
    input  logic                 new_isa_en,
    input  logic                 out_ready,
    output logic                 res_valid,
    output logic                 res_illegal,
    output logic [REG_IDX_W-1:0] res_dst,
    output logic [VEC_W-1:0]     res_data
);
    pipe_t      st_d, st_q;
    dec_t       dec_in;
    logic       adv2, adv1;
    logic [VEC_W-1:0] prod_by_size [NUM_SIZES];
    logic [VEC_W-1:0] prod_sel;

    vmul_eo_decode i_decode (
        .instr  (in_instr),
        .ext_en (new_isa_en),
        .dec    (dec_in)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        vmul_eo_lanes #(
            .VW (VEC_W),
            .EW (BYTE_W << k)
        ) i_lanes (
            .a    (st_q.s1.a),
            .b    (st_q.s1.b),
            .even (st_q.s1.dec.even),
            .sgn  (st_q.s1.dec.sgn),
            .prod (prod_by_size[k])
        );
    end

    assign prod_sel = prod_by_size[st_q.s1.dec.size];

    always_comb begin
        st_d = st_q;
        adv2 = !st_q.s2.occ || out_ready;
        adv1 = !st_q.s1.occ || adv2;
        if (adv2) begin
            st_d.s2.occ  = st_q.s1.occ;
            st_d.s2.ill  = !st_q.s1.dec.legal;
            st_d.s2.dst  = st_q.s1.dec.dst;
            st_d.s2.data = st_q.s1.dec.legal ? prod_sel : '0;
        end
        if (adv1) begin
            st_d.s1.occ = in_valid;
            st_d.s1.dec = dec_in;
            st_d.s1.a   = in_src_a;
            st_d.s1.b   = in_src_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready    = adv1;
    assign res_valid   = st_q.s2.occ && !st_q.s2.ill;
    assign res_illegal = st_q.s2.occ && st_q.s2.ill;
    assign res_dst     = st_q.s2.dst;
    assign res_data    = st_q.s2.data;

    // R11: reset empties the output stage
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_illegal));

    // R7: doubleword form with the newer level off never decodes as legal
    p_dword_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_instr[7:6] == 2'b11 && !new_isa_en) |-> !dec_in.legal);

    // R8: illegal completion carries zero data
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (res_data == '0));

    // R10: stalled legal result holds
    p_hold_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !out_ready) |=>
            (res_valid && $stable(res_data) && $stable(res_dst)));

    // R10: stalled illegal completion holds
    p_hold_illegal_r10: assert property (@(posedge clk) disable iff (rst)
        (res_illegal && !out_ready) |=> (res_illegal && $stable(res_dst)));

    // R9: full pipeline under back-pressure refuses input
    p_full_stall_r9: assert property (@(posedge clk) disable iff (rst)
        ((res_valid || res_illegal) && !out_ready && st_q.s1.occ) |-> !in_ready);
endmodule

// File: tb/test_vmul_eo_unit.sv
`timescale 1ns/1ps
module test_vmul_eo_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_instr = '0;
    logic [127:0] in_src_a = '0;
    logic [127:0] in_src_b = '0;
    logic         new_isa_en = 1'b1;
    logic         out_ready = 1'b1;
    logic         res_valid, res_illegal;
    logic [4:0]   res_dst;
    logic [127:0] res_data;

    typedef struct {
        logic         ill;
        logic [127:0] data;
        logic [4:0]   dst;
        int           acc;
        bit           lat;
        string        tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit lat_mode = 1'b1;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vmul_eo_unit i_vmul_eo_unit (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_instr (in_instr), .in_src_a (in_src_a), .in_src_b (in_src_b),
        .new_isa_en (new_isa_en), .out_ready (out_ready),
        .res_valid (res_valid), .res_illegal (res_illegal),
        .res_dst (res_dst), .res_data (res_data)
    );

    function automatic logic [31:0] mk(input logic e, input logic s,
                                       input logic [1:0] z, input logic [4:0] d);
        return {6'b000100, d, 5'd3, 5'd7, 1'b0, e, s, z, 6'b001000};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // independent reference model built from the requirements
    function automatic void model(input logic [31:0] ins, input logic [127:0] a,
                                  input logic [127:0] b, input logic en,
                                  output logic ill, output logic [127:0] d);
        int w, nprod, e;
        logic [255:0] ma, mb, pr, emask, pmask;
        bit ok;
        ok = (ins[31:26] == 6'b000100) && !ins[10] && (ins[5:0] == 6'b001000)
             && (ins[7:6] != 2'b11 || en);
        d = '0;
        ill = !ok;
        if (!ok) return;
        w = 8 << ins[7:6];
        nprod = 128 / (2 * w);
        emask = (256'd1 << w) - 1;
        pmask = (256'd1 << (2 * w)) - 1;
        for (int p = 0; p < nprod; p++) begin
            e  = 2 * p + (ins[9] ? 0 : 1);
            ma = ({128'd0, a} >> (128 - (e + 1) * w)) & emask;
            mb = ({128'd0, b} >> (128 - (e + 1) * w)) & emask;
            if (ins[8] && ma[w-1]) ma = ma - (256'd1 << w);
            if (ins[8] && mb[w-1]) mb = mb - (256'd1 << w);
            pr = (ma * mb) & pmask;
            d  = d | (pr[127:0] << (128 - (p + 1) * 2 * w));
        end
    endfunction

    task automatic send(input logic [31:0] ins, input logic [127:0] a,
                        input logic [127:0] b, input logic en, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; in_src_a = a; in_src_b = b; new_isa_en = en;
        #1;
        if (lat_mode) begin
            checks++;
            if (!in_ready) begin
                errors++;
                $display("FAIL R9 in_ready actual %0b expected 1", in_ready);
            end
        end
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        model(ins, a, b, en, it.ill, it.data);
        it.dst = ins[25:21];
        it.acc = cyc + 1;
        it.lat = lat_mode;
        it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // back-pressure generator
    always @(posedge clk) begin
        #1;
        out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    // monitor / scoreboard
    bit           prev_present = 1'b0;
    bit           prev_ready = 1'b1;
    logic [127:0] prev_data;
    logic [4:0]   prev_dst;
    logic         prev_ill;
    always @(negedge clk) begin
        bit present;
        item_t it;
        present = res_valid || res_illegal;
        if (!rst) begin
            if (prev_present && !prev_ready) begin
                checks++;
                if (!present || res_data !== prev_data || res_dst !== prev_dst
                    || res_illegal !== prev_ill) begin
                    errors++;
                    $display("FAIL R10 hold: data %h dst %0d ill %0b expected %h %0d %0b",
                             res_data, res_dst, res_illegal, prev_data, prev_dst, prev_ill);
                end
            end
            if (present && out_ready) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected output data %h expected none", res_data);
                end else begin
                    it = q.pop_front();
                    checks++;
                    if (res_illegal !== it.ill || res_valid !== !it.ill
                        || res_data !== it.data || res_dst !== it.dst) begin
                        errors++;
                        $display("FAIL %s (R12 dst) actual ill %0b dst %0d data %h expected ill %0b dst %0d data %h",
                                 it.tag, res_illegal, res_dst, res_data, it.ill, it.dst, it.data);
                    end
                    if (it.lat) begin
                        checks++;
                        if (cyc != it.acc + 1) begin
                            errors++;
                            $display("FAIL R9 latency actual cycle %0d expected %0d", cyc, it.acc + 1);
                        end
                    end
                end
            end
        end
        prev_present = present;
        prev_ready = out_ready;
        prev_data = res_data;
        prev_dst = res_dst;
        prev_ill = res_illegal;
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        logic [127:0] pa, pb, neg;
        neg = {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF};
        pa = 128'h80FF_7F01_8000_FFFF_1234_5678_9ABC_DEF0;
        pb = 128'hFF80_0280_7FFF_8001_FEDC_BA98_7654_3210;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_illegal !== 1'b0) begin
            errors++;
            $display("FAIL R11 during reset valid %0b illegal %0b expected 0 0", res_valid, res_illegal);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_illegal !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 after reset valid %0b illegal %0b ready %0b expected 0 0 1",
                     res_valid, res_illegal, in_ready);
        end

        // all sixteen forms, sizes R4, parity R2, signedness R3, doubleword R5
        for (int z = 0; z < 4; z++)
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < 2; e++)
                    send(mk(e[0], s[0], z[1:0], 5'(z * 4 + s * 2 + e)), pa, pb, 1'b1, "R2/R3/R4/R5");
        // R6: most negative doubleword values
        send(mk(1'b1, 1'b1, 2'b11, 5'd20), neg, neg, 1'b1, "R6 min*min");
        send(mk(1'b1, 1'b1, 2'b11, 5'd21), neg, {neg[63:0], neg[127:64]}, 1'b1, "R6 min*max");
        send(mk(1'b0, 1'b0, 2'b11, 5'd22), '1, '1, 1'b1, "R5 unsigned ones");
        // R7 gating and R1 pattern mismatches, completing as R8
        send(mk(1'b1, 1'b1, 2'b11, 5'd23), pa, pb, 1'b0, "R7 dword gated R8");
        send(mk(1'b0, 1'b1, 2'b10, 5'd24), pa, pb, 1'b0, "R7 word ungated");
        send(mk(1'b1, 1'b0, 2'b00, 5'd25) ^ 32'h0400_0000, pa, pb, 1'b1, "R1 primary R8");
        send(mk(1'b1, 1'b0, 2'b00, 5'd26) | 32'h0000_0400, pa, pb, 1'b1, "R1 bit10 R8");
        send(mk(1'b1, 1'b0, 2'b00, 5'd27) ^ 32'h0000_0001, pa, pb, 1'b1, "R1 suffix R8");
        // random back-to-back traffic
        for (int i = 0; i < 120; i++)
            send(mk($urandom % 2 == 1, $urandom % 2 == 1, 2'($urandom), 5'($urandom)),
                 rnd128(), rnd128(), 1'b1, "R9 stream");
        repeat (4) @(posedge clk);
        // back-pressure with mixed legal and illegal words
        lat_mode = 1'b0;
        stall_mode = 1'b1;
        for (int i = 0; i < 200; i++)
            send(($urandom % 8 == 0) ? $urandom
                                     : mk($urandom % 2 == 1, $urandom % 2 == 1, 2'($urandom), 5'($urandom)),
                 rnd128(), rnd128(), $urandom % 2 == 1, "R10 stall");
        stall_mode = 1'b0;
        repeat (20) @(posedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R10 undelivered items actual %0d expected 0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule